// File: doc/BRIEF.md
# Half-Precision Compare Flag Unit

This unit compares two IEEE half-precision operands and registers the result one clock later. Every compare yields a four-bit condition word. It packs the negative, zero, carry and overflow flags so that a scalar branch can use the result directly. Vector compares also yield a lane mask that is either all ones or all zeros. A sticky invalid-operation flag records any compare that saw a NaN it was not allowed to see.

Seven compare kinds are selected by a 3-bit code:

| Code | Compare kind |
|------|--------------|
| 0 | Quiet scalar |
| 1 | Signalling scalar |
| 2 | Vector equal |
| 3 | Vector greater-or-equal |
| 4 | Vector greater-than |
| 5 | Vector magnitude greater-or-equal |
| 6 | Vector magnitude greater-than |

Code 7 is an idle code. A flush control can make subnormal inputs count as zero. The exponent and mantissa widths are parameters, so the same unit can serve other binary formats.

Top module: `fcmp_unit`

## Requirements
- R1: When the operands compare equal, flags_o (N,Z,C,V in bits 3..0) is 4'b0110. A positive zero and a negative zero compare equal.
- R2: When operand a is less than operand b, flags_o is 4'b1000.
- R3: When operand a is greater than operand b, flags_o is 4'b0010.
- R4: When either operand is a NaN, flags_o is 4'b0011. A NaN has exponent bits 14:10 all ones and a nonzero mantissa in bits 9:0.
- R5: mask_o is 16'hFFFF when the vector test holds and 16'h0000 otherwise. Equal holds only on equal. Greater-or-equal holds on greater or equal. Greater-than holds only on greater. An unordered result never holds. Scalar codes 0 and 1 leave mask_o at zero.
- R6: Codes 5 and 6 clear the sign bit (bit 15) of both operands before comparing. Both flags_o and mask_o then reflect the magnitude relation.
- R7: Codes 0 and 2 raise invalid only for a signalling NaN, which is a NaN with mantissa bit 9 clear. All other codes raise it for any NaN.
- R8: invalid_o is sticky. Once set, it stays set until reset.
- R9: With flush_i high, a subnormal operand (exponent zero, mantissa nonzero) compares as a zero of its own sign. With flush_i low, it compares by its value.
- R10: Results appear on the outputs at the clock edge that samples valid_i high with a code other than 7. Otherwise the outputs hold.
- R11: After reset, flags_o, mask_o and invalid_o are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Compare request strobe |
| op_i | input | 3 | Compare kind code |
| flush_i | input | 1 | Treat subnormal inputs as signed zero |
| a_i | input | 16 | First operand |
| b_i | input | 16 | Second operand |
| flags_o | output | 4 | N,Z,C,V condition word |
| mask_o | output | 16 | Vector lane mask |
| invalid_o | output | 1 | Sticky invalid-operation flag |

## Verification
The bench builds the unit with its default widths: 5 exponent bits and 10 mantissa bits. This keeps the half-precision encoding space small. Random operands drawn by class then hit zeros of both signs, subnormals, infinities, and quiet and signalling NaNs with every compare code and both flush settings. Periodic resets restart the sticky flag, so the invalid rule of each code is observed many times from a clean state.

// File: rtl/fcmp_pkg.sv
package fcmp_pkg;
  typedef enum logic [2:0] {
    OP_SCMP_Q = 3'd0,
    OP_SCMP_S = 3'd1,
    OP_VEQ    = 3'd2,
    OP_VGE    = 3'd3,
    OP_VGT    = 3'd4,
    OP_VAGE   = 3'd5,
    OP_VAGT   = 3'd6,
    OP_NONE   = 3'd7
  } fcmp_op_e;

  typedef enum logic [1:0] {
    REL_EQ,
    REL_LT,
    REL_GT,
    REL_UN
  } fcmp_rel_e;

  // N,Z,C,V
  localparam logic [3:0] FL_EQ = 4'b0110;
  localparam logic [3:0] FL_LT = 4'b1000;
  localparam logic [3:0] FL_GT = 4'b0010;
  localparam logic [3:0] FL_UN = 4'b0011;
endpackage

// File: rtl/fcmp_classify.sv
module fcmp_classify #(
  parameter int EXP_W = 5,
  parameter int MAN_W = 10,
  localparam int W = 1 + EXP_W + MAN_W
) (
  input  logic [W-1:0] val_i,
  input  logic         flush_i,
  input  logic         abs_i,
  output logic         nan_o,
  output logic         snan_o,
  output logic         zero_o,
  output logic [W-1:0] key_o
);
  logic [EXP_W-1:0] exp_f;
  logic [MAN_W-1:0] man_f;
  logic [W-2:0]     mag;
  logic             sgn;

  assign exp_f  = val_i[W-2 -: EXP_W];
  assign man_f  = val_i[MAN_W-1:0];
  assign nan_o  = (&exp_f) && (|man_f);
  assign snan_o = nan_o && !man_f[MAN_W-1];
  assign sgn    = abs_i ? 1'b0 : val_i[W-1];

  always_comb begin
    mag = val_i[W-2:0];
    if (flush_i && (exp_f == '0)) mag = '0;
  end

  assign zero_o = (mag == '0);
  // monotonic unsigned ordering key for sign-magnitude values
  assign key_o  = sgn ? {1'b0, ~mag} : {1'b1, mag};
endmodule

// File: rtl/fcmp_relate.sv
module fcmp_relate
  import fcmp_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         nan_a_i,
  input  logic         nan_b_i,
  input  logic         zero_a_i,
  input  logic         zero_b_i,
  input  logic [W-1:0] key_a_i,
  input  logic [W-1:0] key_b_i,
  output fcmp_rel_e    rel_o
);
  always_comb begin
    if (nan_a_i || nan_b_i)        rel_o = REL_UN;
    else if (zero_a_i && zero_b_i) rel_o = REL_EQ;
    else if (key_a_i == key_b_i)   rel_o = REL_EQ;
    else if (key_a_i < key_b_i)    rel_o = REL_LT;
    else                           rel_o = REL_GT;
  end
endmodule

// File: rtl/fcmp_unit.sv
module fcmp_unit
  import fcmp_pkg::*;
#(
  parameter int EXP_W = 5,
  parameter int MAN_W = 10,
  localparam int W = 1 + EXP_W + MAN_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         valid_i,
  input  logic [2:0]   op_i,
  input  logic         flush_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [3:0]   flags_o,
  output logic [W-1:0] mask_o,
  output logic         invalid_o
);
  fcmp_op_e  op;
  fcmp_rel_e rel;
  logic      abs_mode, fire, quiet_mode, test_ok, is_vec;
  logic [1:0]   nan_v, snan_v, zero_v;
  logic [W-1:0] key_v [2];
  logic [W-1:0] opnd_v [2];
  logic [3:0]   flags_n;
  logic [W-1:0] mask_n;
  logic         inv_n;

  assign op         = fcmp_op_e'(op_i);
  assign abs_mode   = (op == OP_VAGE) || (op == OP_VAGT);
  assign quiet_mode = (op == OP_SCMP_Q) || (op == OP_VEQ);
  assign is_vec     = (op != OP_SCMP_Q) && (op != OP_SCMP_S);
  assign fire       = valid_i && (op != OP_NONE);
  assign opnd_v[0]  = a_i;
  assign opnd_v[1]  = b_i;

  for (genvar g = 0; g < 2; g++) begin : g_cls
    fcmp_classify #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_cls (
      .val_i  (opnd_v[g]),
      .flush_i(flush_i),
      .abs_i  (abs_mode),
      .nan_o  (nan_v[g]),
      .snan_o (snan_v[g]),
      .zero_o (zero_v[g]),
      .key_o  (key_v[g])
    );
  end

  fcmp_relate #(.W(W)) u_rel (
    .nan_a_i (nan_v[0]),
    .nan_b_i (nan_v[1]),
    .zero_a_i(zero_v[0]),
    .zero_b_i(zero_v[1]),
    .key_a_i (key_v[0]),
    .key_b_i (key_v[1]),
    .rel_o   (rel)
  );

  always_comb begin
    unique case (rel)
      REL_EQ:  flags_n = FL_EQ;
      REL_LT:  flags_n = FL_LT;
      REL_GT:  flags_n = FL_GT;
      default: flags_n = FL_UN;
    endcase
    unique case (op)
      OP_VEQ:          test_ok = (rel == REL_EQ);
      OP_VGE, OP_VAGE: test_ok = (rel == REL_EQ) || (rel == REL_GT);
      OP_VGT, OP_VAGT: test_ok = (rel == REL_GT);
      default:         test_ok = 1'b0;
    endcase
    mask_n = (is_vec && test_ok) ? '1 : '0;
    inv_n  = quiet_mode ? (|snan_v) : (|nan_v);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flags_o   <= '0;
      mask_o    <= '0;
      invalid_o <= 1'b0;
    end else if (fire) begin
      flags_o   <= flags_n;
      mask_o    <= mask_n;
      invalid_o <= invalid_o | inv_n;
    end
  end

  // assertions
  logic a_nan_port;
  assign a_nan_port = (&a_i[W-2 -: EXP_W]) && (|a_i[MAN_W-1:0]);

  assert_nan_unordered_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i != 3'd7 && a_nan_port) |=> (flags_o == 4'b0011));

  assert_mask_form_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_o == '0) || (mask_o == '1));

  assert_invalid_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    invalid_o |=> invalid_o);

  assert_hold_idle_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(valid_i && op_i != 3'd7) |=> ($stable(flags_o) && $stable(mask_o) && $stable(invalid_o)));

  assert_flag_code_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flags_o == 4'b0000) || (flags_o == 4'b0110) || (flags_o == 4'b1000) ||
    (flags_o == 4'b0010) || (flags_o == 4'b0011));

  assert_scalar_nomask_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i <= 3'd1) |=> (mask_o == '0));
endmodule

// File: tb/tb_fcmp_unit.sv
module tb_fcmp_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0;
  logic [2:0]  op = 3'd0;
  logic        flush = 1'b0;
  logic [15:0] a = '0, b = '0;
  logic [3:0]  flags;
  logic [15:0] mask;
  logic        invalid;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;
  logic m_sticky = 1'b0;

  always #10 clk = ~clk;

  fcmp_unit dut (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .op_i(op), .flush_i(flush),
    .a_i(a), .b_i(b), .flags_o(flags), .mask_o(mask), .invalid_o(invalid)
  );

  function automatic bit is_nan(input logic [15:0] x);
    return (x[14:10] == 5'h1f) && (x[9:0] != 0);
  endfunction

  function automatic int sval(input logic [15:0] x, input bit flush_m, input bit absm);
    int m;
    m = int'(x[14:0]);
    if (flush_m && x[14:10] == 0) m = 0;
    return (x[15] && !absm) ? -m : m;
  endfunction

  function automatic void model(input logic [15:0] xa, xb, input logic [2:0] cop,
                                input bit fl, output logic [3:0] ef,
                                output logic [15:0] em, output logic ei);
    bit absm, un, ok;
    int va, vb;
    absm = (cop == 3'd5) || (cop == 3'd6);
    un = is_nan(xa) || is_nan(xb);
    va = sval(xa, fl, absm);
    vb = sval(xb, fl, absm);
    if (un) ef = 4'b0011;
    else if (va == vb) ef = 4'b0110;
    else if (va < vb) ef = 4'b1000;
    else ef = 4'b0010;
    case (cop)
      3'd2:       ok = !un && va == vb;
      3'd3, 3'd5: ok = !un && va >= vb;
      3'd4, 3'd6: ok = !un && va > vb;
      default:    ok = 0;
    endcase
    em = ok ? 16'hFFFF : 16'h0000;
    if (cop == 3'd0 || cop == 3'd2)
      ei = (is_nan(xa) && !xa[9]) || (is_nan(xb) && !xb[9]);
    else
      ei = un;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    valid = 1'b0;
    m_sticky = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  // issue one compare; outputs checked one negedge later
  task automatic issue(input logic [15:0] xa, xb, input logic [2:0] cop, input bit fl);
    @(negedge clk);
    a = xa; b = xb; op = cop; flush = fl; valid = 1'b1;
    @(negedge clk);
    valid = 1'b0;
  endtask

  task automatic run_check(input logic [15:0] xa, xb, input logic [2:0] cop, input bit fl,
                           input string tag);
    logic [3:0] ef; logic [15:0] em; logic ei;
    issue(xa, xb, cop, fl);
    model(xa, xb, cop, fl, ef, em, ei);
    if (cop != 3'd7) m_sticky = m_sticky | ei;
    chk({tag, " flags"}, 32'(flags), 32'(ef));
    chk({tag, " mask"}, 32'(mask), 32'(em));
    chk({tag, " invalid"}, 32'(invalid), 32'(m_sticky));
  endtask

  function automatic logic [15:0] rnd_opnd();
    logic [15:0] x;
    int cls;
    cls = $urandom_range(0, 6);
    x[15] = $urandom_range(0, 1);
    case (cls)
      0: x[14:0] = '0;
      1: begin x[14:10] = 0; x[9:0] = 10'($urandom_range(1, 1023)); end
      2, 6: begin x[14:10] = 5'($urandom_range(1, 30)); x[9:0] = 10'($urandom); end
      3: begin x[14:10] = 5'h1f; x[9:0] = 0; end
      4: begin x[14:10] = 5'h1f; x[9:0] = {1'b1, 9'($urandom)}; end
      default: begin x[14:10] = 5'h1f; x[9:0] = {1'b0, 9'($urandom_range(1, 511))}; end
    endcase
    return x;
  endfunction

  function automatic string rel_tag(input logic [3:0] ef);
    case (ef)
      4'b0110: return "R1";
      4'b1000: return "R2";
      4'b0010: return "R3";
      default: return "R4";
    endcase
  endfunction

  initial begin
    #(20 * 150000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [3:0] ef; logic [15:0] em; logic ei;
    void'($urandom(32'd20240611));
    repeat (2) @(negedge clk);
    // R11 reset state
    chk("R11 flags", 32'(flags), 0);
    chk("R11 mask", 32'(mask), 0);
    chk("R11 invalid", 32'(invalid), 0);
    rst_n = 1'b1;

    // R1 +0 vs -0
    issue(16'h0000, 16'h8000, 3'd0, 0);
    chk("R1 zero sign", 32'(flags), 32'h6);
    // R2 1.0 < 2.0
    issue(16'h3C00, 16'h4000, 3'd1, 0);
    chk("R2 less", 32'(flags), 32'h8);
    // R3 -1.0 > -2.0
    issue(16'hBC00, 16'hC000, 3'd0, 0);
    chk("R3 greater", 32'(flags), 32'h2);
    // R5 GE on equal, GT on equal
    issue(16'h4200, 16'h4200, 3'd3, 0);
    chk("R5 ge equal", 32'(mask), 32'hFFFF);
    issue(16'h4200, 16'h4200, 3'd4, 0);
    chk("R5 gt equal", 32'(mask), 32'h0);
    // R6 |-3| > |2|
    issue(16'hC200, 16'h4000, 3'd6, 0);
    chk("R6 abs gt mask", 32'(mask), 32'hFFFF);
    chk("R6 abs gt flags", 32'(flags), 32'h2);
    issue(16'hC200, 16'h4000, 3'd4, 0);
    chk("R6 signed gt mask", 32'(mask), 32'h0);
    // R9 flush
    issue(16'h0001, 16'h0000, 3'd0, 1);
    chk("R9 flush on", 32'(flags), 32'h6);
    issue(16'h0001, 16'h0000, 3'd0, 0);
    chk("R9 flush off", 32'(flags), 32'h2);
    // R7 quiet with quiet NaN: no invalid; R4 unordered
    issue(16'h7E00, 16'h3C00, 3'd0, 0);
    chk("R4 unordered", 32'(flags), 32'h3);
    chk("R7 quiet qnan", 32'(invalid), 0);
    issue(16'h7E00, 16'h3C00, 3'd2, 0);
    chk("R7 veq qnan", 32'(invalid), 0);
    chk("R5 unordered eq mask", 32'(mask), 0);
    // R10 hold on op 7 and on valid low
    issue(16'h7C01, 16'h7C01, 3'd7, 0);
    chk("R10 op7 flags", 32'(flags), 32'h3);
    chk("R10 op7 invalid", 32'(invalid), 0);
    @(negedge clk);
    a = 16'h3C00; b = 16'h3C00; op = 3'd2; valid = 1'b0;
    @(negedge clk);
    chk("R10 idle", 32'(mask), 0);
    // R7 signalling compare with quiet NaN raises
    issue(16'h3C00, 16'hFE00, 3'd1, 0);
    chk("R7 signalling qnan", 32'(invalid), 1);
    // R8 sticky through an ordinary compare
    issue(16'h3C00, 16'h3C00, 3'd0, 0);
    chk("R8 sticky", 32'(invalid), 1);
    do_reset();
    chk("R8 cleared by reset", 32'(invalid), 0);
    issue(16'h7C01, 16'h0000, 3'd0, 0);
    chk("R7 quiet snan", 32'(invalid), 1);

    // random phase
    do_reset();
    for (int i = 0; i < 3000; i++) begin
      logic [15:0] xa, xb; logic [2:0] cop; bit fl;
      if (i % 50 == 49) do_reset();
      xa = rnd_opnd();
      xb = ($urandom_range(0, 7) == 0) ? xa : rnd_opnd();
      cop = 3'($urandom_range(0, 6));
      fl = $urandom_range(0, 1);
      model(xa, xb, cop, fl, ef, em, ei);
      run_check(xa, xb, cop, fl,
                (cop >= 3'd5) ? {"R6 ", rel_tag(ef)} : (cop >= 3'd2 ? {"R5 ", rel_tag(ef)} : rel_tag(ef)));
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule